// File: doc/BRIEF.md
# Loss-of-Signal Detector with Hysteresis

This block watches the received line one unit interval at a time. On every strobe of `ui_stb` it takes an unsigned peak-amplitude code and a recovered NRZ bit. A loss-of-signal flag, `los`, is raised only after the peak has stayed under a low threshold for a full persistence window of consecutive strobes. It is cleared only after the peak has stayed at or over a higher threshold for a window of the same length. The gap between the two thresholds gives the flag hysteresis, so a signal sitting near one level cannot make the flag chatter.

While the flag is set, the NRZ output is forced to zero. Two mode controls turn detection off: a monitor-mode input and a local-loopback input. While either is high, the flag is held low, any partial run is discarded, and data passes through unsquelched. For a nominal peak code of 1024, the default thresholds are 115 (about 19 dB down) and 129 (about 18 dB down). The default window is 110 strobes. At 155.52 Mbit/s one strobe is one unit interval.

Top module: `los_detector`

## Requirements
- R1: With `los` low and detection enabled, `los` rises on the clock edge that samples the PERSIST-th consecutive strobe (default 110) whose `peak_code` is below TH_ASSERT (default 115). After 109 such strobes it is still low.
- R2: With `los` high and detection enabled, `los` falls on the clock edge that samples the PERSIST-th consecutive strobe whose `peak_code` is at or above TH_CLEAR (default 129).
- R3: On every strobe, `rx_bit_sq` takes `rx_bit` if `los` after that edge is low, and 0 if it is high. Whenever `los` is high, `rx_bit_sq` is 0.
- R4: A single strobe on the wrong side of the active threshold restarts the run from zero. For asserting, the wrong side is a code of 115 or more. For clearing, it is a code below 129.
- R5: A strobe with a code from 115 to 128 leaves `los` unchanged and restarts the run.
- R6: While `mon_mode` is high, `los` is low from the next edge on and the run is discarded. On strobes, `rx_bit_sq` follows `rx_bit`.
- R7: `loc_loop` high has the same effect as R6.
- R8: After synchronous reset, `los` and `rx_bit_sq` are 0 and the run count is zero, so a full PERSIST low strobes are needed to assert.
- R9: Cycles with `ui_stb` low change neither `los` nor `rx_bit_sq` and do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ui_stb | input | 1 | One pulse per unit interval |
| peak_code | input | PEAK_W (11) | Unsigned peak amplitude code |
| rx_bit | input | 1 | Recovered NRZ bit |
| mon_mode | input | 1 | Monitor mode, disables detection |
| loc_loop | input | 1 | Local loopback, disables detection |
| los | output | 1 | Registered loss-of-signal flag |
| rx_bit_sq | output | 1 | Registered, squelched NRZ bit |

## Verification
The bench builds the block with its default parameters: an 11-bit peak code, thresholds 115 and 129, and a 110-strobe window. The exact edge of change on the 110th strobe is therefore checked at full length. Directed runs of 109 and 110 strobes sit on each side of that edge, a lone wrong-side or in-between sample interrupts a run, and reset or a mode control lands in mid-run. Random segments of low, in-between, high and noisy peaks, some longer than 110 strobes, are mixed with gaps in the strobe and short mode pulses, so both directions of the hysteresis are reached many times.

// File: rtl/los_pkg.sv
package los_pkg;
  // Level class of one peak sample relative to the two thresholds
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;
endpackage

// File: rtl/los_classify.sv
module los_classify
  import los_pkg::*;
#(
  parameter int PEAK_W    = 11,
  parameter int TH_ASSERT = 115,
  parameter int TH_CLEAR  = 129
) (
  input  logic [PEAK_W-1:0] peak,
  output lvl_e              lvl
);
  localparam logic [PEAK_W-1:0] LO_CODE = PEAK_W'(TH_ASSERT);
  localparam logic [PEAK_W-1:0] HI_CODE = PEAK_W'(TH_CLEAR);

  always_comb begin
    if (peak < LO_CODE)       lvl = LVL_LOW;
    else if (peak >= HI_CODE) lvl = LVL_HIGH;
    else                      lvl = LVL_MID;
  end
endmodule

// File: rtl/los_persist.sv
module los_persist
  import los_pkg::*;
#(
  parameter int PERSIST = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic det_off,
  input  lvl_e lvl,
  output logic los_q,
  output logic los_nxt
);
  localparam int              CNT_W = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERSIST - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             qual;

  always_comb begin
    cnt_d   = cnt_q;
    los_nxt = los_q;
    qual    = los_q ? (lvl == LVL_HIGH) : (lvl == LVL_LOW);
    if (det_off) begin
      cnt_d   = '0;
      los_nxt = 1'b0;
    end else if (stb) begin
      if (!qual) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        cnt_d   = '0;
        los_nxt = ~los_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      los_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      los_q <= los_nxt;
    end
  end
endmodule

// File: rtl/los_squelch.sv
module los_squelch (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic los_nxt,
  input  logic din,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= 1'b0;
    else if (stb) dout <= din & ~los_nxt;
  end
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int PEAK_W    = 11,
  parameter int TH_ASSERT = 115,
  parameter int TH_CLEAR  = 129,
  parameter int PERSIST   = 110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ui_stb,
  input  logic [PEAK_W-1:0] peak_code,
  input  logic              rx_bit,
  input  logic              mon_mode,
  input  logic              loc_loop,
  output logic              los,
  output logic              rx_bit_sq
);
  lvl_e lvl;
  logic det_off;
  logic los_nxt;

  assign det_off = mon_mode | loc_loop;

  los_classify #(
    .PEAK_W   (PEAK_W),
    .TH_ASSERT(TH_ASSERT),
    .TH_CLEAR (TH_CLEAR)
  ) u_classify (
    .peak(peak_code),
    .lvl (lvl)
  );

  los_persist #(
    .PERSIST(PERSIST)
  ) u_persist (
    .clk    (clk),
    .rst    (rst),
    .stb    (ui_stb),
    .det_off(det_off),
    .lvl    (lvl),
    .los_q  (los),
    .los_nxt(los_nxt)
  );

  los_squelch u_squelch (
    .clk    (clk),
    .rst    (rst),
    .stb    (ui_stb),
    .los_nxt(los_nxt),
    .din    (rx_bit),
    .dout   (rx_bit_sq)
  );
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
  parameter int PEAK_W    = 11,
  parameter int TH_ASSERT = 115,
  parameter int TH_CLEAR  = 129
) (
  input logic              clk,
  input logic              rst,
  input logic              ui_stb,
  input logic [PEAK_W-1:0] peak_code,
  input logic              mon_mode,
  input logic              loc_loop,
  input logic              los,
  input logic              rx_bit_sq
);
  logic lo_s, hi_s;
  assign lo_s = peak_code < PEAK_W'(TH_ASSERT);
  assign hi_s = peak_code >= PEAK_W'(TH_CLEAR);

  assert_squelch_R3: assert property (@(posedge clk) disable iff (rst)
    los |-> !rx_bit_sq);

  assert_rise_low_R1: assert property (@(posedge clk) disable iff (rst)
    !los && ui_stb && !mon_mode && !loc_loop && !lo_s |=> !los);

  assert_fall_high_R2: assert property (@(posedge clk) disable iff (rst)
    los && ui_stb && !mon_mode && !loc_loop && !hi_s |=> los);

  assert_mon_off_R6: assert property (@(posedge clk) disable iff (rst)
    mon_mode |=> !los);

  assert_loop_off_R7: assert property (@(posedge clk) disable iff (rst)
    loc_loop |=> !los);

  assert_hold_nostb_R9: assert property (@(posedge clk) disable iff (rst)
    !ui_stb && !mon_mode && !loc_loop |=> $stable(los) && $stable(rx_bit_sq));
endmodule

bind los_detector los_detector_chk #(
  .PEAK_W   (PEAK_W),
  .TH_ASSERT(TH_ASSERT),
  .TH_CLEAR (TH_CLEAR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ui_stb   (ui_stb),
  .peak_code(peak_code),
  .mon_mode (mon_mode),
  .loc_loop (loc_loop),
  .los      (los),
  .rx_bit_sq(rx_bit_sq)
);

// File: tb/test_los_detector.sv
`timescale 1ns/1ps
module test_los_detector;
  localparam int W  = 11;
  localparam int TA = 115;
  localparam int TC = 129;
  localparam int P  = 110;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ui_stb = 1'b0;
  logic [W-1:0] peak_code = '0;
  logic         rx_bit = 1'b0;
  logic         mon_mode = 1'b0;
  logic         loc_loop = 1'b0;
  logic         los, rx_bit_sq;

  int checks = 0;
  int fails  = 0;
  bit m_los  = 1'b0;
  int m_cnt  = 0;
  bit m_dout = 1'b0;

  always #2.5 clk = ~clk;

  los_detector i_los_detector (
    .clk(clk), .rst(rst), .ui_stb(ui_stb), .peak_code(peak_code),
    .rx_bit(rx_bit), .mon_mode(mon_mode), .loc_loop(loc_loop),
    .los(los), .rx_bit_sq(rx_bit_sq)
  );

  function automatic bit qualifies(bit cur, int pk);
    return cur ? (pk >= TC) : (pk < TA);
  endfunction

  task automatic check(string tag);
    checks++;
    if (los !== m_los || rx_bit_sq !== m_dout) begin
      fails++;
      $display("FAIL %s: los=%0b rx_bit_sq=%0b expected los=%0b rx_bit_sq=%0b",
               tag, los, rx_bit_sq, m_los, m_dout);
    end
  endtask

  task automatic step(bit s, int pk, bit d, bit mon, bit lp, string tag);
    ui_stb = s; peak_code = W'(pk); rx_bit = d; mon_mode = mon; loc_loop = lp;
    @(posedge clk);
    #1;
    if (mon || lp) begin
      m_los = 1'b0; m_cnt = 0;
      if (s) m_dout = d;
    end else if (s) begin
      if (!qualifies(m_los, pk)) m_cnt = 0;
      else if (m_cnt == P - 1) begin m_los = !m_los; m_cnt = 0; end
      else m_cnt++;
      m_dout = m_los ? 1'b0 : d;
    end
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; ui_stb = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    m_los = 1'b0; m_cnt = 0; m_dout = 1'b0;
    check("R8");
  endtask

  task automatic run(int n, int pk, string tag);
    for (int i = 0; i < n; i++) step(1'b1, pk, 1'(i), 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: edge on the 110th low strobe, R3 squelch from that edge
    run(P - 1, 114, "R1");
    step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R1");
    if (los !== 1'b1) begin fails++; $display("FAIL R1: los=%0b expected 1", los); end
    checks++;
    run(20, 10, "R3");
    // R5: in-between codes hold the state
    run(30, 115, "R5");
    run(30, 128, "R5");
    // R4 and R5: interrupted clear runs
    run(P - 1, 129, "R2");
    step(1'b1, 128, 1'b1, 1'b0, 1'b0, "R5");
    run(P - 1, 600, "R4");
    step(1'b1, 50, 1'b1, 1'b0, 1'b0, "R4");
    run(P - 1, 2047, "R2");
    step(1'b1, 129, 1'b1, 1'b0, 1'b0, "R2");
    if (los !== 1'b0) begin fails++; $display("FAIL R2: los=%0b expected 0", los); end
    checks++;
    // R4: wrong-side sample during an assert run
    run(P - 1, 0, "R4");
    step(1'b1, 115, 1'b1, 1'b0, 1'b0, "R4");
    run(P - 1, 0, "R4");
    // R9: gaps do not break the run or move the output
    for (int i = 0; i < 20; i++) step(1'b0, 900, 1'(i), 1'b0, 1'b0, "R9");
    step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 20; i++) step(1'b0, 0, 1'(i), 1'b0, 1'b0, "R9");
    // R6: monitor mode clears the flag and the run
    step(1'b0, 0, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 0, 1'b1, 1'b1, 1'b0, "R6");
    run(P - 1, 0, "R6");
    step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R6");
    // R7: local loopback likewise
    step(1'b1, 0, 1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 0, 1'b0, 1'b0, 1'b1, "R7");
    run(P - 1, 0, "R7");
    step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R7");
    // R8: reset in mid-run restarts the count
    run(100, 0, "R8");
    do_reset();
    run(P - 1, 0, "R8");
    step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R8");
    // Random segments
    void'($urandom(32'h1A5E_0D17));
    for (int seg = 0; seg < 60; seg++) begin
      int kind = int'($urandom_range(0, 4));
      int len  = int'($urandom_range(40, 240));
      for (int i = 0; i < len; i++) begin
        int  pk;
        bit  s   = ($urandom_range(0, 3) != 0);
        bit  mon = ($urandom_range(0, 999) == 0);
        bit  lp  = ($urandom_range(0, 999) == 0);
        case (kind)
          0: pk = int'($urandom_range(0, TA - 1));
          1: pk = int'($urandom_range(TC, 2047));
          2: pk = int'($urandom_range(TA, TC - 1));
          3: pk = ($urandom_range(0, 199) == 0) ? 128 : int'($urandom_range(0, 114));
          default: pk = int'($urandom_range(0, 2047));
        endcase
        step(s, pk, 1'($urandom()), mon, lp, m_los ? "R2" : "R1");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule